// File: doc/BRIEF.md
# Temporal Operand Belt

This block is an operand store shaped like a conveyor. Functional-unit results enter at the front and every entry already held moves further back. Once an entry is pushed past the last slot it is lost. Writers give no destination. Where a value lands follows only from the order in which values arrive. Readers name an operand by its age: position 0 is the newest value, position 1 the one before it, and so on up to `DEPTH-1`.

Several result ports can drop values in the same clock cycle, and all of them enter the belt in a single step. A fill input, used to bring back values saved elsewhere, enters the belt the same way as any result. Any number of independent read ports sample the belt by position without a clock edge in between. Each read returns the contents as they were before that cycle's drops, together with a flag that marks a slot nothing has reached since reset.

Top module: `temporal_belt`

## Requirements
- R1: After reset, every position reads as data 0 with the invalid flag at 1.
- R2: A single valid drop makes that value readable at position 0 after the next rising edge, and the value previously at position 0 moves to position 1.
- R3: Each later drop raises a held value's position by the number of values dropped in that cycle. A value pushed beyond position `DEPTH-1` is lost, and `DEPTH-1` then holds the next-younger value.
- R4: Values dropped in the same cycle are ordered by port index. The lowest-numbered valid result port (bit 0 of `drop_vld`, data in `drop_data[WIDTH-1:0]`) lands at position 0, the next valid port at position 1, and so on.
- R5: When K values drop in one cycle, every held value moves back by exactly K positions and the K oldest values are discarded.
- R6: Every read port can address any position. Ports that address the same position in the same cycle return the same data.
- R7: Reads are combinational and return the contents from before the drops of the current cycle.
- R8: A position that no drop has reached since reset returns zero data with its invalid flag at 1. A position that holds a value has its invalid flag at 0.
- R9: A cycle with no valid drop leaves every position unchanged.
- R10: A valid fill drops its value like a result port. It is ordered after all result ports of the same cycle.
- R11: Data on a drop or fill port whose valid bit is 0 has no effect on the belt.
- R12: `DEPTH` must be 8, 16 or 32, and the number of drop sources (`NDROP+1`) must not exceed `DEPTH`. Other values are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| drop_vld | input | NDROP | Valid bit per result drop port |
| drop_data | input | NDROP*WIDTH | Result data, port j in bits [j*WIDTH +: WIDTH] |
| fill_vld | input | 1 | Valid bit of the fill drop |
| fill_data | input | WIDTH | Fill data |
| rd_pos | input | NREAD*$clog2(DEPTH) | Belt position per read port |
| rd_data | output | NREAD*WIDTH | Read data per port |
| rd_inval | output | NREAD | Per port: position holds no value yet |

## Verification
The bench builds the belt with a depth of 8, three result ports, the fill input and three read ports. With four sources able to drop at once, half the belt can turn over in a single cycle. Overflow off the far end, multi-source ordering with gaps in the valid mask, and the fill's place behind the result ports are therefore all reached within a few cycles. Random reads on three ports often land on the same position, and some cycles drive every port to one position on purpose.

// File: rtl/belt_pkg.sv
package belt_pkg;

   // Legal conveyor lengths
   function automatic bit depth_ok(input int d);
      return (d == 8) || (d == 16) || (d == 32);
   endfunction

   // Width of a counter able to hold 0..n
   function automatic int cnt_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/belt_drop_pack.sv
module belt_drop_pack #(
   parameter int WIDTH = 32,
   parameter int NSRC  = 4,
   parameter int CW    = 3
) (
   input  logic [NSRC-1:0]       src_vld,
   input  logic [NSRC*WIDTH-1:0] src_data,
   output logic [CW-1:0]         drop_cnt,
   output logic [NSRC*WIDTH-1:0] pk_data
);

   // Compact valid sources: lowest index first, slot 0 = newest
   always_comb begin
      int slot;
      slot    = 0;
      pk_data = '0;
      for (int j = 0; j < NSRC; j++) begin
         if (src_vld[j]) begin
            pk_data[slot*WIDTH +: WIDTH] = src_data[j*WIDTH +: WIDTH];
            slot = slot + 1;
         end
      end
      drop_cnt = CW'(slot);
   end

endmodule

// File: rtl/belt_store.sv
module belt_store #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32,
   parameter int NSRC  = 4,
   parameter int CW    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CW-1:0]          drop_cnt,
   input  logic [NSRC*WIDTH-1:0]  pk_data,
   output logic [DEPTH*WIDTH-1:0] ent_q_flat,
   output logic [DEPTH-1:0]       ent_vld
);

   logic [WIDTH-1:0] ent_q   [DEPTH];
   logic [WIDTH-1:0] ent_nxt [DEPTH];
   logic [DEPTH-1:0] vld_nxt;

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_ent
         localparam int PK_IDX = (gi < NSRC) ? gi : 0;

         // Entry gi takes a new value or the one K slots nearer the front
         always_comb begin
            ent_nxt[gi] = ent_q[gi];
            vld_nxt[gi] = ent_vld[gi];
            for (int k = 1; k <= NSRC; k++) begin
               if (int'(drop_cnt) == k) begin
                  if (gi < k) begin
                     ent_nxt[gi] = pk_data[PK_IDX*WIDTH +: WIDTH];
                     vld_nxt[gi] = 1'b1;
                  end else begin
                     ent_nxt[gi] = ent_q[(gi >= k) ? gi - k : 0];
                     vld_nxt[gi] = ent_vld[(gi >= k) ? gi - k : 0];
                  end
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ent_q[gi]   <= '0;
               ent_vld[gi] <= 1'b0;
            end else begin
               ent_q[gi]   <= ent_nxt[gi];
               ent_vld[gi] <= vld_nxt[gi];
            end
         end

         assign ent_q_flat[gi*WIDTH +: WIDTH] = ent_q[gi];
      end
   endgenerate

endmodule

// File: rtl/belt_read_port.sv
module belt_read_port #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32,
   parameter int PW    = 4
) (
   input  logic [PW-1:0]          pos,
   input  logic [DEPTH*WIDTH-1:0] ent_q_flat,
   input  logic [DEPTH-1:0]       ent_vld,
   output logic [WIDTH-1:0]       data,
   output logic                   inval
);

   logic hit;

   assign hit   = ent_vld[pos];
   assign inval = ~hit;
   assign data  = hit ? ent_q_flat[pos*WIDTH +: WIDTH] : '0;

endmodule

// File: rtl/temporal_belt.sv
module temporal_belt #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32,
   parameter int NDROP = 3,
   parameter int NREAD = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int NSRC = NDROP + 1,
   localparam int CW   = belt_pkg::cnt_width(NSRC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NDROP-1:0]       drop_vld,
   input  logic [NDROP*WIDTH-1:0] drop_data,
   input  logic                   fill_vld,
   input  logic [WIDTH-1:0]       fill_data,
   input  logic [NREAD*PW-1:0]    rd_pos,
   output logic [NREAD*WIDTH-1:0] rd_data,
   output logic [NREAD-1:0]       rd_inval
);

   // R12 elaboration checks
   generate
      if (!belt_pkg::depth_ok(DEPTH)) begin : g_bad_depth
         $error("temporal_belt: DEPTH must be 8, 16 or 32");
      end
      if (NSRC > DEPTH) begin : g_bad_src
         $error("temporal_belt: more drop sources than positions");
      end
      if (NREAD < 1 || WIDTH < 1 || NDROP < 1) begin : g_bad_size
         $error("temporal_belt: port counts and width must be positive");
      end
   endgenerate

   // Fill sits after the result ports in drop order
   logic [NSRC-1:0]        src_vld;
   logic [NSRC*WIDTH-1:0]  src_data;
   logic [CW-1:0]          drop_cnt;
   logic [NSRC*WIDTH-1:0]  pk_data;
   logic [DEPTH*WIDTH-1:0] ent_q_flat;
   logic [DEPTH-1:0]       ent_vld;

   assign src_vld  = {fill_vld, drop_vld};
   assign src_data = {fill_data, drop_data};

   belt_drop_pack #(
      .WIDTH (WIDTH),
      .NSRC  (NSRC),
      .CW    (CW)
   ) u_pack (
      .src_vld  (src_vld),
      .src_data (src_data),
      .drop_cnt (drop_cnt),
      .pk_data  (pk_data)
   );

   belt_store #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH),
      .NSRC  (NSRC),
      .CW    (CW)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .drop_cnt   (drop_cnt),
      .pk_data    (pk_data),
      .ent_q_flat (ent_q_flat),
      .ent_vld    (ent_vld)
   );

   genvar gr;
   generate
      for (gr = 0; gr < NREAD; gr++) begin : g_rd
         belt_read_port #(
            .DEPTH (DEPTH),
            .WIDTH (WIDTH),
            .PW    (PW)
         ) u_rd (
            .pos        (rd_pos[gr*PW +: PW]),
            .ent_q_flat (ent_q_flat),
            .ent_vld    (ent_vld),
            .data       (rd_data[gr*WIDTH +: WIDTH]),
            .inval      (rd_inval[gr])
         );
      end
   endgenerate

endmodule

// File: rtl/belt_chk.sv
module belt_chk #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32,
   parameter int NDROP = 3,
   parameter int NREAD = 4,
   parameter int CW    = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NDROP-1:0]       drop_vld,
   input logic [NDROP*WIDTH-1:0] drop_data,
   input logic                   fill_vld,
   input logic [CW-1:0]          drop_cnt,
   input logic [DEPTH*WIDTH-1:0] ent_q_flat,
   input logic [DEPTH-1:0]       ent_vld,
   input logic [NREAD*WIDTH-1:0] rd_data,
   input logic [NREAD-1:0]       rd_inval
);

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt == '0) |=> ($stable(ent_q_flat) && $stable(ent_vld)));

   // R5
   drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(drop_cnt) == $countones({fill_vld, drop_vld}));

   // R2
   single_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt == CW'(1)) |=>
         ((ent_q_flat[2*WIDTH-1:WIDTH] == $past(ent_q_flat[WIDTH-1:0])) &&
          (ent_vld[1] == $past(ent_vld[0]))));

   // R4
   front_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_vld[0] |=> (ent_q_flat[WIDTH-1:0] == $past(drop_data[WIDTH-1:0])));

   // R8
   fill_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ent_vld + 1'b1) & ent_vld) == '0);

   genvar gr;
   generate
      for (gr = 0; gr < NREAD; gr++) begin : g_rdchk
         // R8
         inval_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_inval[gr] |-> (rd_data[gr*WIDTH +: WIDTH] == '0));
      end
   endgenerate

endmodule

bind temporal_belt belt_chk #(
   .DEPTH (DEPTH),
   .WIDTH (WIDTH),
   .NDROP (NDROP),
   .NREAD (NREAD),
   .CW    (CW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .drop_vld   (drop_vld),
   .drop_data  (drop_data),
   .fill_vld   (fill_vld),
   .drop_cnt   (drop_cnt),
   .ent_q_flat (ent_q_flat),
   .ent_vld    (ent_vld),
   .rd_data    (rd_data),
   .rd_inval   (rd_inval)
);

// File: tb/tb_temporal_belt.sv
module tb_temporal_belt;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int WIDTH = 16;
   localparam int NDROP = 3;
   localparam int NREAD = 3;
   localparam int PW    = $clog2(DEPTH);

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic [NDROP-1:0]       drop_vld;
   logic [NDROP*WIDTH-1:0] drop_data;
   logic                   fill_vld;
   logic [WIDTH-1:0]       fill_data;
   logic [NREAD*PW-1:0]    rd_pos;
   logic [NREAD*WIDTH-1:0] rd_data;
   logic [NREAD-1:0]       rd_inval;

   int n_tests = 0;
   int n_fail  = 0;

   logic [WIDTH-1:0] m_d [DEPTH];
   bit               m_v [DEPTH];

   temporal_belt #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH),
      .NDROP (NDROP),
      .NREAD (NREAD)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .drop_vld  (drop_vld),
      .drop_data (drop_data),
      .fill_vld  (fill_vld),
      .fill_data (fill_data),
      .rd_pos    (rd_pos),
      .rd_data   (rd_data),
      .rd_inval  (rd_inval)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk_val(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: data actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_bit(string tag, logic act, logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: flag actual %b expected %b", tag, act, exp);
      end
   endtask

   // Reference: ordered drop list, then shift by its length
   function automatic void model_update();
      logic [WIDTH-1:0] nv [NDROP+1];
      int k;
      k = 0;
      for (int j = 0; j < NDROP; j++)
         if (drop_vld[j]) begin nv[k] = drop_data[j*WIDTH +: WIDTH]; k++; end
      if (fill_vld) begin nv[k] = fill_data; k++; end
      for (int i = DEPTH-1; i >= 0; i--) begin
         if (i >= k) begin m_d[i] = m_d[i-k]; m_v[i] = m_v[i-k]; end
         else        begin m_d[i] = nv[i];    m_v[i] = 1'b1;     end
      end
   endfunction

   task automatic check_reads(string tag);
      for (int r = 0; r < NREAD; r++) begin
         int p;
         p = int'(rd_pos[r*PW +: PW]);
         chk_val(tag, rd_data[r*WIDTH +: WIDTH], m_v[p] ? m_d[p] : '0);
         chk_bit(tag, rd_inval[r], !m_v[p]);
      end
   endtask

   // Called at a falling edge with inputs set; checks pre-drop reads (R7)
   task automatic step(string tag);
      #1;
      check_reads(tag);
      @(posedge clk);
      model_update();
      @(negedge clk);
      drop_vld = '0;
      fill_vld = 1'b0;
   endtask

   task automatic peek(int p);
      rd_pos[PW-1:0] = PW'(p);
      #1;
   endtask

   task automatic clear_in();
      drop_vld  = '0;
      drop_data = '0;
      fill_vld  = 1'b0;
      fill_data = '0;
      rd_pos    = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < DEPTH; i++) begin m_d[i] = '0; m_v[i] = 1'b0; end
      clear_in();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: all positions empty after reset
      for (int p = 0; p < DEPTH; p++) begin
         peek(p);
         chk_val("R1", rd_data[WIDTH-1:0], '0);
         chk_bit("R1", rd_inval[0], 1'b1);
      end

      // R2: single drops
      drop_vld = 3'b001; drop_data[WIDTH-1:0] = 16'h1111;
      step("R7");
      peek(0); chk_val("R2", rd_data[WIDTH-1:0], 16'h1111);
      drop_vld = 3'b001; drop_data[WIDTH-1:0] = 16'h2222;
      step("R7");
      peek(0); chk_val("R2", rd_data[WIDTH-1:0], 16'h2222);
      peek(1); chk_val("R2", rd_data[WIDTH-1:0], 16'h1111);

      // R8: filled vs never-filled
      peek(1); chk_bit("R8", rd_inval[0], 1'b0);
      peek(2); chk_bit("R8", rd_inval[0], 1'b1);
      chk_val("R8", rd_data[WIDTH-1:0], '0);

      // R9 / R11: garbage on invalid ports
      drop_vld = '0; drop_data = {3{16'hDEAD}}; fill_vld = 1'b0; fill_data = 16'hBEEF;
      step("R11");
      peek(0); chk_val("R11", rd_data[WIDTH-1:0], 16'h2222);
      peek(1); chk_val("R9", rd_data[WIDTH-1:0], 16'h1111);
      peek(2); chk_bit("R11", rd_inval[0], 1'b1);

      // R4 / R10 / R5: ports 0 and 2 plus fill in one cycle
      drop_vld = 3'b101;
      drop_data = {16'h4444, 16'h9999, 16'h3333};
      fill_vld = 1'b1; fill_data = 16'h5555;
      step("R7");
      peek(0); chk_val("R4", rd_data[WIDTH-1:0], 16'h3333);
      peek(1); chk_val("R4", rd_data[WIDTH-1:0], 16'h4444);
      peek(2); chk_val("R10", rd_data[WIDTH-1:0], 16'h5555);
      peek(3); chk_val("R5", rd_data[WIDTH-1:0], 16'h2222);
      peek(4); chk_val("R5", rd_data[WIDTH-1:0], 16'h1111);
      peek(5); chk_bit("R5", rd_inval[0], 1'b1);

      // R3: push 0x1111 to the last slot, then off the end
      for (int i = 1; i <= 3; i++) begin
         drop_vld = 3'b010; drop_data[2*WIDTH-1:WIDTH] = WIDTH'(16'h0F00 + i);
         step("R7");
      end
      peek(7); chk_val("R3", rd_data[WIDTH-1:0], 16'h1111);
      peek(0); chk_val("R3", rd_data[WIDTH-1:0], 16'h0F03);
      drop_vld = 3'b100; drop_data[3*WIDTH-1:2*WIDTH] = 16'h0F04;
      step("R7");
      peek(7); chk_val("R3", rd_data[WIDTH-1:0], 16'h2222);

      // R10: fill alone
      fill_vld = 1'b1; fill_data = 16'h6666;
      step("R7");
      peek(0); chk_val("R10", rd_data[WIDTH-1:0], 16'h6666);
      peek(1); chk_val("R10", rd_data[WIDTH-1:0], 16'h0F04);

      // R6 / R7: random traffic against the reference
      for (int c = 0; c < 400; c++) begin
         drop_vld  = NDROP'($urandom);
         drop_data = {NDROP{WIDTH'($urandom)}} ^ (NDROP*WIDTH)'({$urandom, $urandom});
         fill_vld  = (($urandom % 4) == 0);
         fill_data = WIDTH'($urandom);
         if ((c % 5) == 0) begin
            rd_pos = {NREAD{PW'($urandom)}};
            step("R6");
         end else begin
            rd_pos = (NREAD*PW)'($urandom);
            step("R7");
         end
      end

      // R5: full-rate drops (four at once) then check all ports
      drop_vld = '1; drop_data = {16'hA003, 16'hA002, 16'hA001};
      fill_vld = 1'b1; fill_data = 16'hA004;
      step("R5");
      rd_pos = {3'd4, 3'd3, 3'd0};
      #1;
      chk_val("R5", rd_data[WIDTH-1:0], 16'hA001);
      chk_val("R5", rd_data[2*WIDTH-1:WIDTH], 16'hA004);
      check_reads("R5");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule